// File: doc/BRIEF.md
# Status Register and Write-Protection Guard

This block is the protection core of a serial non-volatile memory controller. It holds the write enable latch and a small configuration register. That register carries a protect-enable flag and a two-bit block-protect level. The block answers "may this byte be programmed?" for any array address the command decoder presents. It also vets status-register updates against a hardware write-protect pin, and it assembles the byte returned when the host reads the status.

The command decoder drives the block with single-cycle strobes. One strobe sets the latch and another clears it. A load strobe captures a status byte while the select line is still active, and a commit strobe marks the moment the select line is released. A busy input comes from the internal programming timer. A new status value takes effect only through the commit path. It is reported by a one-cycle start pulse, which the controller uses to launch its programming cycle. When the busy input falls, the block returns to the write-disabled state.

Top module: `wpguard_top`

## Requirements
- R1: After reset, `status_o` reads 8'h00, `arr_allow_o` is 0 and `sr_start_o` is 0. The latch is clear, and the flag and level are 0.
- R2: When `busy_i` is 0, `status_o` is {flag, 3'b000, level[1:0], latch, 1'b0}. The flag is at bit 7, the level at bits 3:2 and the latch at bit 1.
- R3: While `busy_i` is 1, `status_o` reads 8'hFF.
- R4: A `wel_set_i` strobe sets the latch one cycle later, and a `wel_clr_i` strobe clears it one cycle later, whatever the state of `wp_n_i`. If both strobes arrive in the same cycle, the clear wins. While `busy_i` is 1, both strobes are ignored.
- R5: In the cycle after `busy_i` falls from 1 to 0, the latch reads 0.
- R6: The level selects the protected range: 00 protects nothing, 01 the top quarter of the address space (3000h-3FFFh at 14 bits), 10 the top half (2000h-3FFFh), and 11 all addresses. `arr_allow_o` is 0 for any protected address.
- R7: For an address outside the protected range, `arr_allow_o` is 1 exactly when the latch is set and `busy_i` is 0.
- R8: A commit that follows a load, with the latch set, `busy_i` at 0 and hardware protection off, raises `sr_start_o` for one cycle. In that same cycle, bit 7 and bits 3:2 of the loaded byte become the flag and the level. Loaded bits 6:4 and 1:0 are never stored.
- R9: Hardware protection is active when `wp_n_i` is 0 and the flag is 1. While it is active, a commit produces no start pulse, and the flag and level keep their values.
- R10: With the flag at 0, `wp_n_i` has no effect, and a status commit depends only on the latch.
- R11: If hardware protection becomes active in any cycle between a load and its commit, that pending update is cancelled, even if `wp_n_i` goes high again before the commit.
- R12: A commit with no load pending has no effect. A load made while `busy_i` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wel_set_i | input | 1 | Strobe: set write enable latch |
| wel_clr_i | input | 1 | Strobe: clear write enable latch |
| sr_load_i | input | 1 | Strobe: capture a pending status byte |
| sr_data_i | input | 8 | Status byte to capture |
| sr_commit_i | input | 1 | Strobe: select released, apply the pending status byte |
| wp_n_i | input | 1 | Write-protect pin, active low |
| busy_i | input | 1 | Internal programming cycle in progress |
| addr_i | input | ADDR_W | Array address being queried |
| arr_allow_o | output | 1 | Array write to `addr_i` is permitted |
| sr_start_o | output | 1 | One-cycle pulse: status update accepted |
| status_o | output | 8 | Status read byte |

## Verification
The bench runs a behavioural model of the block next to the design and compares every output on every cycle, so a wrong latch, flag, level or pending bit shows up at the first clock edge where it matters. A corrupted level shows on `status_o` bits 3:2 and on `arr_allow_o` in the same cycle it is queried. A stale latch shows on bit 1 one cycle after the strobe or after busy falls. A missed cancellation shows as a spurious `sr_start_o` in the cycle after the commit. Directed sequences cover each boundary address and each protection combination. A long randomised run then mixes strobes, pin changes and busy periods.

// File: rtl/wps_pkg.sv
package wps_pkg;

  typedef enum logic [1:0] {
    PROT_NONE = 2'b00,
    PROT_QTR  = 2'b01,
    PROT_HALF = 2'b10,
    PROT_ALL  = 2'b11
  } prot_lvl_e;

  localparam int unsigned SR_W     = 8;
  localparam int unsigned SR_FLAG  = 7;
  localparam int unsigned SR_LV_HI = 3;
  localparam int unsigned SR_LV_LO = 2;
  localparam int unsigned N_LEVELS = 4;

  typedef struct packed {
    logic      flag;
    prot_lvl_e lvl;
  } sr_cfg_t;

endpackage

// File: rtl/wps_region.sv
module wps_region
  import wps_pkg::*;
#(
  parameter int unsigned ADDR_W = 14
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  prot_lvl_e         lvl_i,
  output logic              hit_o
);

  logic [N_LEVELS-1:0] lvl_hit;
  logic [1:0]          lvl_sel;
  logic                unused_low;

  generate
    for (genvar g = 0; g < N_LEVELS; g++) begin : g_lvl
      if (g == 0) begin : g_none
        assign lvl_hit[g] = 1'b0;
      end else if (g == 1) begin : g_qtr
        assign lvl_hit[g] = &addr_i[ADDR_W-1:ADDR_W-2];
      end else if (g == 2) begin : g_half
        assign lvl_hit[g] = addr_i[ADDR_W-1];
      end else begin : g_all
        assign lvl_hit[g] = 1'b1;
      end
    end
  endgenerate

  assign lvl_sel    = lvl_i;
  assign hit_o      = lvl_hit[lvl_sel];
  assign unused_low = ^addr_i[ADDR_W-3:0];

endmodule

// File: rtl/wps_wel.sv
module wps_wel (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic busy_i,
  output logic wel_o
);

  logic wel_q, wel_d;
  logic busy_q;
  logic busy_fell;

  always_comb begin
    busy_fell = busy_q & ~busy_i;
    wel_d     = wel_q;
    if (busy_fell) begin
      wel_d = 1'b0;
    end else if (!busy_i) begin
      if (clr_i)      wel_d = 1'b0;
      else if (set_i) wel_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      wel_q  <= wel_d;
      busy_q <= busy_i;
    end
  end

  assign wel_o = wel_q;

  a_r4_busy_freezes_latch: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(wel_o));
  a_r4_clear_beats_set: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && clr_i && !busy_i) |=> !wel_o);
  a_r5_busy_end_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_i) |=> !wel_o);

endmodule

// File: rtl/wps_sreg.sv
module wps_sreg
  import wps_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [SR_W-1:0] data_i,
  input  logic            commit_i,
  input  logic            wp_n_i,
  input  logic            wel_i,
  input  logic            busy_i,
  output sr_cfg_t         cfg_o,
  output logic            start_o
);

  sr_cfg_t   cfg_q, cfg_d;
  logic      pend_q, pend_d;
  logic      pflag_q;
  prot_lvl_e plvl_q;
  logic      cap_en;
  logic      hw_prot;
  logic      go;
  logic      start_q;
  logic      unused_bits;

  assign hw_prot     = ~wp_n_i & cfg_q.flag;
  assign go          = commit_i & pend_q & wel_i & ~hw_prot & ~busy_i;
  assign cap_en      = load_i & ~busy_i & ~hw_prot & ~commit_i;
  assign unused_bits = ^{data_i[6:4], data_i[1:0]};

  always_comb begin
    pend_d = pend_q;
    if (commit_i)     pend_d = 1'b0;
    else if (hw_prot) pend_d = 1'b0;
    else if (cap_en)  pend_d = 1'b1;
  end

  always_comb begin
    cfg_d = cfg_q;
    if (go) begin
      cfg_d.flag = pflag_q;
      cfg_d.lvl  = plvl_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '{flag: 1'b0, lvl: PROT_NONE};
      pend_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      pend_q  <= pend_d;
      start_q <= go;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pflag_q <= 1'b0;
      plvl_q  <= PROT_NONE;
    end else if (cap_en) begin
      pflag_q <= data_i[SR_FLAG];
      plvl_q  <= prot_lvl_e'(data_i[SR_LV_HI:SR_LV_LO]);
    end
  end

  assign cfg_o   = cfg_q;
  assign start_o = start_q;

  a_r8_start_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> $past(wel_i));
  a_r8_start_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);
  a_r9_pin_blocks_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && !wp_n_i && cfg_q.flag) |=> (!start_o && $stable(cfg_o)));
  a_r10_flag_off_pin_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q.flag && commit_i && pend_q && wel_i && !busy_i) |=> start_o);
  a_r11_cancel_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n_i && cfg_q.flag) |=> (!start_o ##1 !start_o));
  a_r12_no_update_without_start: assert property (@(posedge clk) disable iff (!rst_n)
    !start_o |-> $stable(cfg_o));

endmodule

// File: rtl/wpguard_top.sv
module wpguard_top
  import wps_pkg::*;
#(
  parameter int unsigned ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wel_set_i,
  input  logic              wel_clr_i,
  input  logic              sr_load_i,
  input  logic [7:0]        sr_data_i,
  input  logic              sr_commit_i,
  input  logic              wp_n_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              arr_allow_o,
  output logic              sr_start_o,
  output logic [7:0]        status_o
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       wel;
  sr_cfg_t    cfg;
  logic       region_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  wps_wel u_wel (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .set_i  (wel_set_i),
    .clr_i  (wel_clr_i),
    .busy_i (busy_i),
    .wel_o  (wel)
  );

  wps_sreg u_sreg (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load_i   (sr_load_i),
    .data_i   (sr_data_i),
    .commit_i (sr_commit_i),
    .wp_n_i   (wp_n_i),
    .wel_i    (wel),
    .busy_i   (busy_i),
    .cfg_o    (cfg),
    .start_o  (sr_start_o)
  );

  wps_region #(.ADDR_W(ADDR_W)) u_region (
    .addr_i (addr_i),
    .lvl_i  (cfg.lvl),
    .hit_o  (region_hit)
  );

  always_comb begin
    if (busy_i) status_o = 8'hFF;
    else        status_o = {cfg.flag, 3'b000, cfg.lvl, wel, 1'b0};
  end

  assign arr_allow_o = wel & ~busy_i & ~region_hit;

  a_r3_busy_reads_ones: assert property (@(posedge clk) disable iff (!rst_int_n)
    busy_i |-> (status_o == 8'hFF));
  a_r2_idle_spare_bits_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    !busy_i |-> (status_o[6:4] == 3'b000 && !status_o[0]));
  a_r7_allow_needs_latch: assert property (@(posedge clk) disable iff (!rst_int_n)
    arr_allow_o |-> (status_o[1] && !busy_i));
  a_r6_full_level_blocks: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!busy_i && status_o[3:2] == 2'b11) |-> !arr_allow_o);
  a_r6_top_quarter_blocked: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!busy_i && status_o[3:2] != 2'b00 && (&addr_i[ADDR_W-1:ADDR_W-2])) |-> !arr_allow_o);

endmodule

// File: tb/tb_wpguard_top.sv
`timescale 1ns/1ps
module tb_wpguard_top;

  localparam int ADDR_W = 14;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wel_set_i, wel_clr_i, sr_load_i, sr_commit_i, wp_n_i, busy_i;
  logic [7:0]        sr_data_i;
  logic [ADDR_W-1:0] addr_i;
  logic              arr_allow_o, sr_start_o;
  logic [7:0]        status_o;

  always #2 clk = ~clk;

  wpguard_top #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .wel_set_i(wel_set_i), .wel_clr_i(wel_clr_i),
    .sr_load_i(sr_load_i), .sr_data_i(sr_data_i), .sr_commit_i(sr_commit_i),
    .wp_n_i(wp_n_i), .busy_i(busy_i), .addr_i(addr_i),
    .arr_allow_o(arr_allow_o), .sr_start_o(sr_start_o), .status_o(status_o)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 0;
  string cur_req = "R1";

  bit       m_wel, m_flag, m_pend, m_pflag, m_busy_q, m_start;
  bit [1:0] m_lvl, m_plvl;

  function automatic bit is_prot(int a, bit [1:0] lv);
    int lo;
    case (lv)
      2'd0: lo = DEPTH;
      2'd1: lo = (DEPTH / 4) * 3;
      2'd2: lo = DEPTH / 2;
      default: lo = 0;
    endcase
    return a >= lo;
  endfunction

  task automatic model_step();
    bit hw, go, n_pend, n_wel;
    if (!rst_n) begin
      m_wel = 0; m_flag = 0; m_lvl = 0; m_pend = 0; m_pflag = 0;
      m_plvl = 0; m_busy_q = 0; m_start = 0;
      return;
    end
    hw = !wp_n_i && m_flag;
    go = sr_commit_i && m_pend && m_wel && !hw && !busy_i;
    n_pend = m_pend;
    if (sr_commit_i) n_pend = 0;
    else if (hw) n_pend = 0;
    else if (sr_load_i && !busy_i) begin
      n_pend = 1; m_pflag = sr_data_i[7]; m_plvl = sr_data_i[3:2];
    end
    n_wel = m_wel;
    if (m_busy_q && !busy_i) n_wel = 0;
    else if (!busy_i && wel_clr_i) n_wel = 0;
    else if (!busy_i && wel_set_i) n_wel = 1;
    if (go) begin m_flag = m_pflag; m_lvl = m_plvl; end
    m_pend = n_pend; m_wel = n_wel; m_busy_q = busy_i; m_start = go;
  endtask

  task automatic compare();
    logic [7:0] e_st;
    logic       e_al;
    e_st = busy_i ? 8'hFF : {m_flag, 3'b000, m_lvl, m_wel, 1'b0};
    e_al = m_wel && !busy_i && !is_prot(int'(addr_i), m_lvl);
    n_vec++;
    if (status_o !== e_st || arr_allow_o !== e_al || sr_start_o !== m_start) begin
      n_bad++;
      $display("FAIL %s t=%0t status=%h/%h allow=%b/%b start=%b/%b (actual/expected)",
               cur_req, $time, status_o, e_st, arr_allow_o, e_al, sr_start_o, m_start);
    end
  endtask

  task automatic cyc();
    @(posedge clk); model_step();
    @(negedge clk); compare();
  endtask

  task automatic idle();
    wel_set_i = 0; wel_clr_i = 0; sr_load_i = 0; sr_commit_i = 0;
  endtask

  task automatic wren();  wel_set_i = 1; cyc(); idle(); cyc(); endtask
  task automatic wrdi();  wel_clr_i = 1; cyc(); idle(); cyc(); endtask
  task automatic busy_for(int n);
    busy_i = 1; for (int i = 0; i < n; i++) cyc();
    busy_i = 0; cyc(); cyc();
  endtask
  task automatic sr_write(logic [7:0] d, bit with_busy);
    sr_data_i = d; sr_load_i = 1; cyc(); idle(); cyc();
    sr_commit_i = 1; cyc(); idle(); cyc();
    if (with_busy) busy_for(3);
  endtask
  task automatic sweep();
    int pts[6] = '{0, 'h1FFF, 'h2000, 'h2FFF, 'h3000, 'h3FFF};
    for (int i = 0; i < 6; i++) begin addr_i = pts[i][ADDR_W-1:0]; cyc(); end
  endtask

  initial begin
    idle(); sr_data_i = 0; wp_n_i = 1; busy_i = 0; addr_i = 0; rst_n = 0;
    // R1: reset state
    cur_req = "R1";
    repeat (3) begin @(negedge clk); model_step(); compare(); end
    @(negedge clk); rst_n = 1;
    repeat (3) cyc();
    addr_i = 'h0100; cyc();

    // R4: set, clear, both
    cur_req = "R4"; wren(); wrdi(); wel_set_i = 1; wel_clr_i = 1; cyc(); idle(); cyc();
    wren(); busy_i = 1; wel_clr_i = 1; cyc(); idle(); busy_i = 0; cyc(); cyc();
    // R5: busy end clears latch
    cur_req = "R5"; wren(); busy_for(4);
    // R7: allow follows latch and busy
    cur_req = "R7"; sweep(); wren(); sweep(); busy_i = 1; cyc(); busy_i = 0; cyc();
    // R10: flag 0, pin low, update still accepted
    cur_req = "R10"; wp_n_i = 0; wren(); sr_write(8'h0C, 1); wp_n_i = 1;
    // R6: each level, boundary addresses
    cur_req = "R6";
    for (int lv = 0; lv < 4; lv++) begin
      wren(); sr_write({4'b0000, lv[1:0], 2'b00}, 0); wren(); sweep(); busy_for(2);
    end
    // R8: unused bits of loaded byte dropped
    cur_req = "R8"; wren(); sr_write(8'hF7, 0); cyc(); wren(); sr_write(8'h73, 1);
    // R2: layout with flag and level set
    cur_req = "R2"; wren(); sr_write(8'h88, 0); wren(); cyc();
    // R3: busy forces all ones
    cur_req = "R3"; busy_for(5);
    // R9: pin low with flag 1 blocks update
    cur_req = "R9"; wp_n_i = 0; wren(); sr_write(8'h00, 0); cyc();
    // R11: pin pulse between load and commit cancels
    cur_req = "R11"; wp_n_i = 1; wren();
    sr_data_i = 8'h04; sr_load_i = 1; cyc(); idle();
    wp_n_i = 0; cyc(); wp_n_i = 1; cyc();
    sr_commit_i = 1; cyc(); idle(); cyc();
    // R12: commit without load, load while busy
    cur_req = "R12"; sr_commit_i = 1; cyc(); idle(); cyc();
    busy_i = 1; sr_data_i = 8'h00; sr_load_i = 1; cyc(); idle(); busy_i = 0; cyc();
    wren(); sr_commit_i = 1; cyc(); idle(); cyc();

    // R6 and others under random mixed stimulus
    cur_req = "R6";
    for (int i = 0; i < 4000; i++) begin
      wel_set_i   = ($urandom_range(0, 5) == 0);
      wel_clr_i   = ($urandom_range(0, 15) == 0);
      sr_load_i   = ($urandom_range(0, 5) == 0);
      sr_commit_i = ($urandom_range(0, 5) == 0);
      sr_data_i   = 8'($urandom);
      wp_n_i      = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 9) == 0) busy_i = ~busy_i;
      addr_i      = ADDR_W'($urandom);
      cyc();
    end
    idle(); busy_i = 0; cyc();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule